// File: doc/BRIEF.md
# Wide Register Access Bridge

This block lets a host with a 32-bit register port reach a bank of 64-bit registers. The host sees five 32-bit words: two data halves, a command word, an error-clear word and a status word. A wide access is launched by writing the command word. Bit 31 of the command selects the direction. The low bits carry the inner register address.

For a store, the host first loads both data halves and then writes the command with bit 31 set. The two halves are joined into one 64-bit value and presented to the inner register port. For a fetch, the host writes the command with bit 31 clear. The inner 64-bit value is captured in one step into the holding register, which is shared with the data halves, and the host then reads the two halves.

Every command takes the same number of cycles. A new command may follow in the very next cycle. An address that the inner space does not decode raises a sticky error bit in the status word, and only a write to the error-clear word removes it.

Top module: `wide_reg_bridge`

## Requirements
- R1: Host offsets are decoded on the full host address: 0x00 is the upper data half, 0x04 is the lower data half, 0x08 is the command, 0x18 is the error-clear word and 0x1C is the status word. A read of any other offset returns zero, and a write to any other offset changes no state.
- R2: The word at 0x00 holds bits 63:32 of the 64-bit holding register and the word at 0x04 holds bits 31:0. A host write to either word replaces that half, and a host read returns it.
- R3: A command write with bit 31 set drives `inner_req` high, with `inner_we` high, for exactly the following cycle. In that cycle `inner_addr` equals the command's bits IAW-1:0, and `inner_wdata` is the upper half concatenated with the lower half as they stood when the command was written.
- R4: A command write with bit 31 clear drives `inner_req` high, with `inner_we` low, for the following cycle. When that cycle ends without an error, `inner_rdata` is loaded into the holding register in one step, so both halves show the new value from the second cycle after the command.
- R5: The error flag (status bit 31) becomes set at the end of an access cycle in which `inner_err` is high. It also becomes set one cycle after a command whose bits 30:IAW are not all zero. Such a command raises no `inner_req`. A failed fetch leaves the holding register unchanged.
- R6: The error flag stays set until a host write of any value to 0x18 clears it. If a new error arrives on the same clock edge as the clear, the flag stays set. Status bits 30:0 always read zero.
- R7: Commands may be written on consecutive cycles. Each one produces its own single-cycle inner access in the next cycle, in the order written, without stalls.
- R8: If the host writes a data half in the same cycle that a fetch result is captured, the host's value wins for that half and the capture fills the other half.
- R9: After reset the holding register and the error flag are zero and no inner access is active.
- R10: `host_rdata` is zero in any cycle in which `host_rd` is low. When `host_rd` is high, `host_rdata` shows, in the same cycle, the selected word as it stands before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational |
| inner_req | output | 1 | Inner access active this cycle |
| inner_we | output | 1 | Inner access is a store |
| inner_addr | output | IAW | Inner register address |
| inner_wdata | output | 64 | Inner store value |
| inner_rdata | input | 64 | Inner fetch value, valid while inner_req is high |
| inner_err | input | 1 | Inner address decodes to no register, valid while inner_req is high |

## Verification
If the holding register is corrupted, the corruption appears on the next host read of either data half. Because the same register feeds `inner_wdata`, it also appears on the very next store command. A wrong pending-command stage shows up one cycle after the command: `inner_req`, `inner_we`, `inner_addr` or `inner_wdata` departs from the model at once. A stuck or lost error flag shows up on the first status read after the access cycle, and clear-versus-set ordering is visible on the status read that follows the colliding edge.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
   localparam int WIDE_W    = 64;
   localparam int HALF_W    = 32;
   localparam int N_HALVES  = WIDE_W / HALF_W;
   localparam int OFS_HI    = 'h00;
   localparam int OFS_LO    = 'h04;
   localparam int OFS_CMD   = 'h08;
   localparam int OFS_CLR   = 'h18;
   localparam int OFS_STAT  = 'h1C;
   localparam int DIR_BIT   = 31;
   localparam int ERR_BIT   = 31;
endpackage

// File: rtl/wrb_cmd_stage.sv
module wrb_cmd_stage #(
   parameter int IAW = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       issue,
   input  logic                       issue_we,
   input  logic                       issue_oob,
   input  logic [IAW-1:0]             issue_addr,
   input  logic [wrb_pkg::WIDE_W-1:0] issue_data,
   output logic                       req,
   output logic                       we,
   output logic                       oob,
   output logic [IAW-1:0]             addr,
   output logic [wrb_pkg::WIDE_W-1:0] wdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req   <= 1'b0;
         we    <= 1'b0;
         oob   <= 1'b0;
         addr  <= '0;
         wdata <= '0;
      end else begin
         req <= issue & ~issue_oob;
         oob <= issue & issue_oob;
         if (issue) begin
            we    <= issue_we;
            addr  <= issue_addr;
            wdata <= issue_data;
         end
      end
   end

   // R7: an access lasts only the cycle after its command
   p_single_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> !req);
   // R5: out-of-range command never reaches the inner port
   p_oob_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && issue_oob) |=> !req);
endmodule

// File: rtl/wrb_hold.sv
module wrb_hold (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cap,
   input  logic [wrb_pkg::WIDE_W-1:0]   cap_data,
   input  logic [wrb_pkg::N_HALVES-1:0] wr_half,
   input  logic [wrb_pkg::HALF_W-1:0]   wdata,
   output logic [wrb_pkg::WIDE_W-1:0]   hold
);
   import wrb_pkg::*;

   for (genvar h = 0; h < N_HALVES; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold[h*HALF_W +: HALF_W] <= '0;
         else if (wr_half[h])
            hold[h*HALF_W +: HALF_W] <= wdata;
         else if (cap)
            hold[h*HALF_W +: HALF_W] <= cap_data[h*HALF_W +: HALF_W];
      end
   end

   // R4: without capture or host write the holding register keeps its value
   p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap && wr_half == '0) |=> $stable(hold));
   // R8: a host half-write lands even when a capture collides
   p_host_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_half[N_HALVES-1] |=> hold[WIDE_W-1 -: HALF_W] == $past(wdata));
endmodule

// File: rtl/wrb_err.sv
module wrb_err (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    err <= 1'b0;
      else if (set)  err <= 1'b1;
      else if (clr)  err <= 1'b0;
   end

   // R5: a reported error is always latched
   p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> err);
   // R6: error is held until cleared
   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
   parameter int HOST_AW = 5,
   parameter int IAW     = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_wr,
   input  logic                       host_rd,
   input  logic [HOST_AW-1:0]         host_addr,
   input  logic [31:0]                host_wdata,
   output logic [31:0]                host_rdata,
   output logic                       inner_req,
   output logic                       inner_we,
   output logic [IAW-1:0]             inner_addr,
   output logic [wrb_pkg::WIDE_W-1:0] inner_wdata,
   input  logic [wrb_pkg::WIDE_W-1:0] inner_rdata,
   input  logic                       inner_err
);
   import wrb_pkg::*;

   if (HOST_AW < 5) begin : g_bad_host_aw
      $error("HOST_AW must cover offset 0x1C");
   end
   if (IAW < 1 || IAW > 30) begin : g_bad_iaw
      $error("IAW must lie in 1..30");
   end
   if (HALF_W != 32 || N_HALVES != 2) begin : g_bad_split
      $error("host word must be half the inner word");
   end

   logic sel_hi, sel_lo, sel_cmd, sel_clr, sel_stat;
   assign sel_hi   = host_addr == HOST_AW'(OFS_HI);
   assign sel_lo   = host_addr == HOST_AW'(OFS_LO);
   assign sel_cmd  = host_addr == HOST_AW'(OFS_CMD);
   assign sel_clr  = host_addr == HOST_AW'(OFS_CLR);
   assign sel_stat = host_addr == HOST_AW'(OFS_STAT);

   logic                   issue, issue_oob, oob_q, err_q;
   logic [WIDE_W-1:0]      hold_q;
   logic [N_HALVES-1:0]    wr_half;

   assign issue     = host_wr & sel_cmd;
   assign issue_oob = |host_wdata[DIR_BIT-1:IAW];
   assign wr_half   = {host_wr & sel_hi, host_wr & sel_lo};

   wrb_cmd_stage #(.IAW(IAW)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .issue_we  (host_wdata[DIR_BIT]),
      .issue_oob (issue_oob),
      .issue_addr(host_wdata[IAW-1:0]),
      .issue_data(hold_q),
      .req       (inner_req),
      .we        (inner_we),
      .oob       (oob_q),
      .addr      (inner_addr),
      .wdata     (inner_wdata)
   );

   wrb_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (inner_req & ~inner_we & ~inner_err),
      .cap_data(inner_rdata),
      .wr_half (wr_half),
      .wdata   (host_wdata),
      .hold    (hold_q)
   );

   wrb_err u_err (
      .clk  (clk),
      .rst_n(rst_n),
      .set  ((inner_req & inner_err) | oob_q),
      .clr  (host_wr & sel_clr),
      .err  (err_q)
   );

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         if (sel_hi)        host_rdata = hold_q[WIDE_W-1 -: HALF_W];
         else if (sel_lo)   host_rdata = hold_q[HALF_W-1:0];
         else if (sel_stat) host_rdata[ERR_BIT] = err_q;
      end
   end

   // R3: a command starts an inner access or flags an out-of-range address
   p_cmd_issues_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !issue_oob) |=> inner_req);
   // R3: direction follows command bit 31
   p_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !issue_oob) |=> inner_we == $past(host_wdata[DIR_BIT]));
   // R4: a clean fetch lands in the holding register
   p_fetch_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inner_req && !inner_we && !inner_err && wr_half == '0) |=> hold_q == $past(inner_rdata));
endmodule

// File: tb/wide_reg_bridge_tb.sv
module wide_reg_bridge_tb;
   localparam int IAW = 12;
   localparam logic [4:0] A_HI = 5'h00, A_LO = 5'h04, A_CMD = 5'h08, A_CLR = 5'h18, A_ST = 5'h1C;

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic host_wr = 0, host_rd = 0;
   logic [4:0] host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic inner_req, inner_we, inner_err;
   logic [IAW-1:0] inner_addr;
   logic [63:0] inner_wdata, inner_rdata;

   wide_reg_bridge #(.HOST_AW(5), .IAW(IAW)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .inner_req(inner_req), .inner_we(inner_we), .inner_addr(inner_addr),
      .inner_wdata(inner_wdata), .inner_rdata(inner_rdata), .inner_err(inner_err));

   // inner slave: four registers at 0x100..0x103
   logic [63:0] smem [4];
   logic s_ok;
   assign s_ok        = inner_addr[IAW-1:2] == 10'h040;
   assign inner_err   = inner_req & ~s_ok;
   assign inner_rdata = s_ok ? smem[inner_addr[1:0]] : 64'hBADB_ADBA_DBAD_BADB;
   always @(posedge clk) if (inner_req && inner_we && s_ok) smem[inner_addr[1:0]] <= inner_wdata;

   // behavioural reference
   logic [63:0] m_mem [4];
   logic [63:0] m_hold = '0;
   bit m_err = 0;
   typedef struct { bit we; bit oob; int addr; logic [63:0] data; } cmd_t;
   cmd_t m_q[$];
   int total = 0, bad = 0;
   bit done = 0;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(logic [4:0] a);
      case (a)
         A_HI:    return m_hold[63:32];
         A_LO:    return m_hold[31:0];
         A_ST:    return {m_err, 31'b0};
         default: return 32'h0;
      endcase
   endfunction

   // one host cycle; inputs applied at negedge, results checked before the edge
   task automatic cyc(bit wr, bit rd, logic [4:0] a, logic [31:0] d, string tag);
      bit cap, set;
      cmd_t c;
      host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
      #1;
      check(rd ? tag : "R10", {32'h0, host_rdata}, rd ? {32'h0, exp_read(a)} : 64'h0);
      if (m_q.size() > 0 && !m_q[0].oob) begin
         check("R3 req", {63'h0, inner_req}, 64'h1);
         check("R3 we", {63'h0, inner_we}, {63'h0, m_q[0].we});
         check("R3 addr", {52'h0, inner_addr}, 64'(m_q[0].addr));
         if (m_q[0].we) check("R3 wdata", inner_wdata, m_q[0].data);
      end else
         check("R7 idle", {63'h0, inner_req}, 64'h0);
      @(posedge clk);
      cap = 0; set = 0;
      if (m_q.size() > 0) begin
         c = m_q.pop_front();
         if (c.oob || c.addr < 'h100 || c.addr > 'h103) set = 1;
         else if (c.we) m_mem[c.addr - 'h100] = c.data;
         else cap = 1;
      end
      if (cap) begin
         if (!(wr && a == A_HI)) m_hold[63:32] = m_mem[c.addr - 'h100][63:32];
         if (!(wr && a == A_LO)) m_hold[31:0]  = m_mem[c.addr - 'h100][31:0];
      end
      if (wr && a == A_HI) m_hold[63:32] = d;
      if (wr && a == A_LO) m_hold[31:0] = d;
      if (set) m_err = 1;
      else if (wr && a == A_CLR) m_err = 0;
      if (wr && a == A_CMD) begin
         c.we = d[31]; c.oob = |d[30:IAW]; c.addr = int'(d[IAW-1:0]); c.data = m_hold;
         m_q.push_back(c);
      end
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 5'h0, 32'h0, "R10");
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         smem[i]  = 64'h1111_0000_0000_0000 * (i + 1) + 64'(i);
         m_mem[i] = smem[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R9 reset state
      cyc(0, 1, A_HI, 0, "R9 hi");
      cyc(0, 1, A_LO, 0, "R9 lo");
      cyc(0, 1, A_ST, 0, "R9 status");
      // R2 staging
      cyc(1, 0, A_HI, 32'hCAFE_0001, "R2");
      cyc(1, 0, A_LO, 32'hBEEF_0002, "R2");
      cyc(0, 1, A_HI, 0, "R2 hi");
      cyc(0, 1, A_LO, 0, "R2 lo");
      // R1 unmapped offsets
      cyc(1, 0, 5'h0C, 32'hFFFF_FFFF, "R1");
      cyc(1, 0, 5'h14, 32'hFFFF_FFFF, "R1");
      cyc(0, 1, 5'h0C, 0, "R1 0x0C");
      cyc(0, 1, 5'h10, 0, "R1 0x10");
      cyc(0, 1, A_CMD, 0, "R1 cmd reads zero");
      cyc(0, 1, A_HI, 0, "R1 hi untouched");
      // R3 store, then R4 fetch of another register and of the stored one
      cyc(1, 0, A_CMD, 32'h8000_0101, "R3");
      idle(1);
      cyc(1, 0, A_CMD, 32'h0000_0102, "R4");
      cyc(0, 1, A_HI, 0, "R4 not yet");
      cyc(0, 1, A_HI, 0, "R4 hi");
      cyc(0, 1, A_LO, 0, "R4 lo");
      cyc(1, 0, A_CMD, 32'h0000_0101, "R4");
      idle(1);
      cyc(0, 1, A_HI, 0, "R3 stored hi");
      cyc(0, 1, A_LO, 0, "R3 stored lo");
      // R5 undecoded fetch keeps the holding register
      cyc(1, 0, A_CMD, 32'h0000_0200, "R5");
      idle(1);
      cyc(0, 1, A_ST, 0, "R5 status");
      cyc(0, 1, A_HI, 0, "R5 hold kept");
      idle(3);
      cyc(0, 1, A_ST, 0, "R6 sticky");
      cyc(1, 0, A_CLR, 32'h0, "R6");
      cyc(0, 1, A_ST, 0, "R6 cleared");
      // R5 out-of-range bits: no inner access
      cyc(1, 0, A_CMD, 32'h8000_1101, "R5");
      idle(1);
      cyc(0, 1, A_ST, 0, "R5 oob status");
      cyc(0, 1, A_LO, 0, "R5 oob lo");
      // R6 clear collides with a new error
      cyc(1, 0, A_CLR, 32'h0, "R6");
      cyc(1, 0, A_CMD, 32'h0000_0300, "R6");
      cyc(1, 0, A_CLR, 32'h0, "R6");
      cyc(0, 1, A_ST, 0, "R6 set wins");
      cyc(1, 0, A_CLR, 32'h0, "R6");
      // R7 back-to-back
      cyc(1, 0, A_HI, 32'h0123_4567, "R7");
      cyc(1, 0, A_LO, 32'h89AB_CDEF, "R7");
      cyc(1, 0, A_CMD, 32'h8000_0100, "R7");
      cyc(1, 0, A_CMD, 32'h8000_0103, "R7");
      cyc(1, 0, A_CMD, 32'h0000_0102, "R7");
      cyc(1, 0, A_CMD, 32'h0000_0103, "R7");
      idle(1);
      cyc(0, 1, A_HI, 0, "R7 hi");
      cyc(0, 1, A_LO, 0, "R7 lo");
      cyc(1, 0, A_CMD, 32'h0000_0100, "R7");
      idle(1);
      cyc(0, 1, A_LO, 0, "R7 first store");
      // R8 host write collides with a capture
      cyc(1, 0, A_CMD, 32'h0000_0102, "R8");
      cyc(1, 0, A_HI, 32'h5A5A_5A5A, "R8");
      cyc(0, 1, A_HI, 0, "R8 host half");
      cyc(0, 1, A_LO, 0, "R8 captured half");
      cyc(0, 1, A_ST, 0, "R8 status");
      idle(2);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule